// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) resolves operand dependencies and redirects. It reads the register numbers and the few control bits that sit in the decode/execute, execute/memory and memory/writeback pipeline registers. From these it chooses the source of each execute-stage ALU operand. It detects the single dependency that forwarding cannot cover and turns a branch-redirect request into clear controls for the two front pipeline registers.

The instruction set is small: add, sub, load word, store word, shift-left-logical, add-immediate, or-immediate, branch-if-equal, noop and halt. The block decodes the opcode and function fields itself so that it only ever compares the registers an instruction really reads. A clear request to the decode/execute register is meant to zero its control signals only. The register numbers and operand values already captured there stay as they are. The register file is assumed to write before it reads in the same cycle, so the writeback-to-decode case needs no action here. The register file, ALU, memories and branch predictor live elsewhere.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: An operand select is 01 (take the execute/memory result) when `exm_regwrite` is 1, `exm_wreg` is nonzero, and `exm_wreg` equals a source register the execute-stage instruction reads. With `exm_regwrite` at 0 that stage is never a source.
- R2: When R1 does not apply, an operand select is 10 (take the memory/writeback result) under the same conditions applied to `mwb_regwrite` and `mwb_wreg`. Otherwise the select is 00 (register file value).
- R3: When both later stages match the same operand, the select is 01. The two operands are selected independently.
- R4: A source or destination register number of 0 never produces forwarding or a stall. All-zero inputs give selects 00 and every control output 0.
- R5: The sources read by each instruction are fixed by its encoding. Opcode 0 with funct 32 (add) or funct 34 (sub), opcode 43 (store), and opcode 4 (branch) read both rs and rt. Opcode 0 with funct 0 (shift, and noop) reads only rt. Opcodes 8, 13 and 35 read only rs. Opcode 0 with funct 1 (halt) reads nothing. Both forwarding and the stall check ignore registers an instruction does not read.
- R6: A load-use stall occurs when `ex_memread` is 1, `ex_wreg` is nonzero, and `ex_wreg` equals a source the decode-stage instruction reads. The stall drives `stall_lu`, `pc_hold`, `ifid_hold` and `idex_clear` to 1.
- R7: No other dependency stalls. An execute-stage instruction that is not a load, or a load whose destination the decode-stage instruction does not read, leaves `stall_lu`, `pc_hold` and `ifid_hold` at 0.
- R8: With `id_pred_taken` at 1 and no stall or mispredict, `ifid_clear` is 1, `idex_clear` is 0, and the PC is not held.
- R9: `ex_mispredict` drives `ifid_clear` and `idex_clear` to 1. It overrides a load-use stall in the same cycle, forcing `stall_lu`, `pc_hold` and `ifid_hold` to 0.
- R10: During a load-use stall without a mispredict, a taken prediction in decode is deferred: `ifid_clear` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used to sample the built-in checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| id_op | input | 6 | Opcode of the instruction in decode |
| id_funct | input | 6 | Function field of the instruction in decode |
| id_rs | input | 5 | rs field of the instruction in decode |
| id_rt | input | 5 | rt field of the instruction in decode |
| ex_op | input | 6 | Opcode held in decode/execute |
| ex_funct | input | 6 | Function field held in decode/execute |
| ex_rs | input | 5 | rs held in decode/execute |
| ex_rt | input | 5 | rt held in decode/execute |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| ex_wreg | input | 5 | Destination register of the execute-stage instruction |
| exm_regwrite | input | 1 | Execute/memory instruction writes a register |
| exm_wreg | input | 5 | Destination held in execute/memory |
| mwb_regwrite | input | 1 | Memory/writeback instruction writes a register |
| mwb_wreg | input | 5 | Destination held in memory/writeback |
| id_pred_taken | input | 1 | Predictor redirects fetch for the branch in decode |
| ex_mispredict | input | 1 | Branch in execute was mispredicted |
| fwd_a | output | 2 | rs operand source: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_b | output | 2 | rt operand source, same encoding |
| stall_lu | output | 1 | Load-use stall active |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_clear | output | 1 | Clear the fetch/decode register |
| idex_clear | output | 1 | Clear control signals of decode/execute (bubble) |

## Verification
Every output is a same-cycle function of the inputs, so a wrong decision shows at the ports in the cycle its inputs are applied. A bad source decode gives a wrong select or a spurious stall whenever an unread field happens to match a destination. A broken priority gives a stale operand when two stages match together. A broken override gives a held PC during a mispredict, which would freeze the wrong path one cycle longer. The stimulus therefore pairs each instruction class with destinations that collide with its read fields and with the fields it does not read, and overlaps the stall with both kinds of redirect.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;
  localparam int OP_W  = 6;
  localparam int REG_W = 5;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OP_W-1:0] OPC_LW    = 6'd35;
  localparam logic [OP_W-1:0] OPC_SW    = 6'd43;

  localparam logic [OP_W-1:0] FN_SLL  = 6'd0;
  localparam logic [OP_W-1:0] FN_HALT = 6'd1;
  localparam logic [OP_W-1:0] FN_ADD  = 6'd32;
  localparam logic [OP_W-1:0] FN_SUB  = 6'd34;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EXM = 2'b01,
    FWD_MWB = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
  import pipe_hz_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [OP_W-1:0] funct,
  output logic            reads_rs,
  output logic            reads_rt
);
  always_comb begin
    reads_rs = 1'b0;
    reads_rt = 1'b0;
    case (op)
      OPC_RTYPE: begin
        case (funct)
          FN_ADD, FN_SUB: begin reads_rs = 1'b1; reads_rt = 1'b1; end
          FN_SLL:         reads_rt = 1'b1;
          default:        ; // halt and unknown functions read nothing
        endcase
      end
      OPC_SW, OPC_BEQ:            begin reads_rs = 1'b1; reads_rt = 1'b1; end
      OPC_ADDI, OPC_ORI, OPC_LW:  reads_rs = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import pipe_hz_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] src,
  input  logic          src_used,
  input  logic          exm_rw,
  input  logic [RW-1:0] exm_w,
  input  logic          mwb_rw,
  input  logic [RW-1:0] mwb_w,
  output fwd_sel_e      sel
);
  logic hit_exm, hit_mwb;

  assign hit_exm = src_used && exm_rw && (exm_w != '0) && (exm_w == src);
  assign hit_mwb = src_used && mwb_rw && (mwb_w != '0) && (mwb_w == src);

  always_comb begin
    if (hit_exm)      sel = FWD_EXM;
    else if (hit_mwb) sel = FWD_MWB;
    else              sel = FWD_RF;
  end

  // R3: the nearer stage wins when both match
  p_near_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_exm && hit_mwb) |-> (sel == FWD_EXM));
  // R4: register 0 is never forwarded
  p_zero_src_r4: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> (sel == FWD_RF));
  // R5: an unread field never selects a forward path
  p_unread_r5: assert property (@(posedge clk) disable iff (rst)
    !src_used |-> (sel == FWD_RF));
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
  import pipe_hz_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_rd_rs,
  input  logic          id_rd_rt,
  input  logic          ex_memread,
  input  logic [RW-1:0] ex_wreg,
  input  logic          id_pred_taken,
  input  logic          ex_mispredict,
  output logic          stall_lu,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_clear,
  output logic          idex_clear
);
  logic dep_rs, dep_rt, ld_dep;

  assign dep_rs = id_rd_rs && (id_rs == ex_wreg);
  assign dep_rt = id_rd_rt && (id_rt == ex_wreg);
  assign ld_dep = ex_memread && (ex_wreg != '0) && (dep_rs || dep_rt);

  always_comb begin
    stall_lu   = ld_dep && !ex_mispredict;
    pc_hold    = stall_lu;
    ifid_hold  = stall_lu;
    idex_clear = stall_lu || ex_mispredict;
    ifid_clear = ex_mispredict || (id_pred_taken && !stall_lu);
  end

  // R6: a stall freezes the front end and bubbles decode/execute
  p_stall_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    stall_lu |-> (pc_hold && ifid_hold && idex_clear));
  // R7: only a load in execute can stall
  p_load_only_r7: assert property (@(posedge clk) disable iff (rst)
    !ex_memread |-> (!stall_lu && !pc_hold));
  // R8: a decode-stage redirect clears only fetch/decode
  p_pred_front_r8: assert property (@(posedge clk) disable iff (rst)
    (id_pred_taken && !ex_mispredict && !ld_dep) |-> (ifid_clear && !idex_clear && !pc_hold));
  // R9: a mispredict beats a stall
  p_flush_first_r9: assert property (@(posedge clk) disable iff (rst)
    ex_mispredict |-> (ifid_clear && idex_clear && !pc_hold && !ifid_hold));
  // R10: a stalled decode stage keeps its instruction
  p_stall_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    stall_lu |-> !ifid_clear);
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import pipe_hz_pkg::*;
#(
  parameter int OW = OP_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] id_op,
  input  logic [OW-1:0] id_funct,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic [OW-1:0] ex_op,
  input  logic [OW-1:0] ex_funct,
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic          ex_memread,
  input  logic [RW-1:0] ex_wreg,
  input  logic          exm_regwrite,
  input  logic [RW-1:0] exm_wreg,
  input  logic          mwb_regwrite,
  input  logic [RW-1:0] mwb_wreg,
  input  logic          id_pred_taken,
  input  logic          ex_mispredict,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall_lu,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_clear,
  output logic          idex_clear
);
  localparam int NSRC = 2;

  logic id_rd_rs, id_rd_rt, ex_rd_rs, ex_rd_rt;
  logic [NSRC-1:0][RW-1:0] ex_src;
  logic [NSRC-1:0]         ex_used;
  fwd_sel_e                sel [NSRC];

  hz_src_decode u_dec_id (.op(id_op), .funct(id_funct), .reads_rs(id_rd_rs), .reads_rt(id_rd_rt));
  hz_src_decode u_dec_ex (.op(ex_op), .funct(ex_funct), .reads_rs(ex_rd_rs), .reads_rt(ex_rd_rt));

  assign ex_src  = {ex_rt, ex_rs};
  assign ex_used = {ex_rd_rt, ex_rd_rs};

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    hz_fwd_sel #(.RW(RW)) u_fwd (
      .clk(clk), .rst(rst),
      .src(ex_src[g]), .src_used(ex_used[g]),
      .exm_rw(exm_regwrite), .exm_w(exm_wreg),
      .mwb_rw(mwb_regwrite), .mwb_w(mwb_wreg),
      .sel(sel[g])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  hz_stall_ctl #(.RW(RW)) u_stall (
    .clk(clk), .rst(rst),
    .id_rs(id_rs), .id_rt(id_rt), .id_rd_rs(id_rd_rs), .id_rd_rt(id_rd_rt),
    .ex_memread(ex_memread), .ex_wreg(ex_wreg),
    .id_pred_taken(id_pred_taken), .ex_mispredict(ex_mispredict),
    .stall_lu(stall_lu), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ifid_clear(ifid_clear), .idex_clear(idex_clear)
  );

  // R1: the execute/memory path is chosen only for a writing stage
  p_exm_needs_write_r1: assert property (@(posedge clk) disable iff (rst)
    (fwd_a == 2'b01 || fwd_b == 2'b01) |-> (exm_regwrite && exm_wreg != '0));
  // R2: the memory/writeback path is chosen only for a writing stage
  p_mwb_needs_write_r2: assert property (@(posedge clk) disable iff (rst)
    (fwd_a == 2'b10 || fwd_b == 2'b10) |-> (mwb_regwrite && mwb_wreg != '0));
  // R4: destination register 0 never causes a stall
  p_zero_dest_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_wreg == '0) |-> !stall_lu);
endmodule

// File: tb/test_pipe_hazard_ctl.sv
module test_pipe_hazard_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [5:0] id_op, id_funct, ex_op, ex_funct;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_wreg, exm_wreg, mwb_wreg;
  logic ex_memread, exm_regwrite, mwb_regwrite, id_pred_taken, ex_mispredict;
  logic [1:0] fwd_a, fwd_b;
  logic stall_lu, pc_hold, ifid_hold, ifid_clear, idex_clear;

  pipe_hazard_ctl i_pipe_hazard_ctl (.*);

  // staging copies set by the scenario, driven at the next edge
  logic [5:0] s_id_op, s_id_funct, s_ex_op, s_ex_funct;
  logic [4:0] s_id_rs, s_id_rt, s_ex_rs, s_ex_rt, s_ex_wreg, s_exm_w, s_mwb_w;
  logic s_ex_mr, s_exm_rw, s_mwb_rw, s_pred, s_mis;

  typedef struct {
    logic [1:0] fa, fb;
    logic st, ic, dc;
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  task automatic clr();
    s_id_op = 0; s_id_funct = 0; s_id_rs = 0; s_id_rt = 0;
    s_ex_op = 0; s_ex_funct = 0; s_ex_rs = 0; s_ex_rt = 0;
    s_ex_mr = 0; s_ex_wreg = 0; s_exm_rw = 0; s_exm_w = 0;
    s_mwb_rw = 0; s_mwb_w = 0; s_pred = 0; s_mis = 0;
  endtask

  task automatic set_ex(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] rs, input logic [4:0] rt);
    s_ex_op = op; s_ex_funct = fn; s_ex_rs = rs; s_ex_rt = rt;
  endtask

  task automatic set_id(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] rs, input logic [4:0] rt);
    s_id_op = op; s_id_funct = fn; s_id_rs = rs; s_id_rt = rt;
  endtask

  task automatic apply(input logic [1:0] fa, input logic [1:0] fb, input logic st,
                       input logic ic, input logic dc, input string tag);
    exp_t e;
    @(posedge clk);
    id_op = s_id_op; id_funct = s_id_funct; id_rs = s_id_rs; id_rt = s_id_rt;
    ex_op = s_ex_op; ex_funct = s_ex_funct; ex_rs = s_ex_rs; ex_rt = s_ex_rt;
    ex_memread = s_ex_mr; ex_wreg = s_ex_wreg;
    exm_regwrite = s_exm_rw; exm_wreg = s_exm_w;
    mwb_regwrite = s_mwb_rw; mwb_wreg = s_mwb_w;
    id_pred_taken = s_pred; ex_mispredict = s_mis;
    e.fa = fa; e.fb = fb; e.st = st; e.ic = ic; e.dc = dc; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (fwd_a !== e.fa || fwd_b !== e.fb || stall_lu !== e.st || pc_hold !== e.st ||
          ifid_hold !== e.st || ifid_clear !== e.ic || idex_clear !== e.dc) begin
        errors++;
        $display("FAIL %s: got fa=%b fb=%b st=%b ph=%b ih=%b ic=%b dc=%b, expected fa=%b fb=%b st=%b ph=%b ih=%b ic=%b dc=%b",
                 e.tag, fwd_a, fwd_b, stall_lu, pc_hold, ifid_hold, ifid_clear, idex_clear,
                 e.fa, e.fb, e.st, e.st, e.st, e.ic, e.dc);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    apply(2'b00, 2'b00, 0, 0, 0, "R4 reset all-zero");
    apply(2'b00, 2'b00, 0, 0, 0, "R4 reset all-zero second cycle");
    @(posedge clk); rst = 1'b0;

    // forwarding
    clr(); set_ex(0, 32, 5, 6); s_exm_rw = 1; s_exm_w = 5;
    apply(2'b01, 2'b00, 0, 0, 0, "R1 add rs from exe/mem");
    clr(); set_ex(0, 34, 3, 7); s_exm_rw = 1; s_exm_w = 7;
    apply(2'b00, 2'b01, 0, 0, 0, "R1 sub rt from exe/mem");
    clr(); set_ex(0, 32, 5, 6); s_exm_w = 5; s_mwb_w = 6;
    apply(2'b00, 2'b00, 0, 0, 0, "R1 no write enable no forward");
    clr(); set_ex(0, 32, 9, 10); s_mwb_rw = 1; s_mwb_w = 10;
    apply(2'b00, 2'b10, 0, 0, 0, "R2 add rt from mem/wb");
    clr(); set_ex(0, 32, 4, 4); s_exm_rw = 1; s_exm_w = 4; s_mwb_rw = 1; s_mwb_w = 4;
    apply(2'b01, 2'b01, 0, 0, 0, "R3 both match nearer wins");
    clr(); set_ex(0, 32, 4, 8); s_exm_rw = 1; s_exm_w = 8; s_mwb_rw = 1; s_mwb_w = 4;
    apply(2'b10, 2'b01, 0, 0, 0, "R3 independent operands");
    clr(); set_ex(0, 32, 0, 0); s_exm_rw = 1; s_mwb_rw = 1;
    apply(2'b00, 2'b00, 0, 0, 0, "R4 register zero not forwarded");

    // source decode
    clr(); set_ex(8, 0, 2, 11); s_exm_rw = 1; s_exm_w = 11; s_mwb_rw = 1; s_mwb_w = 2;
    apply(2'b10, 2'b00, 0, 0, 0, "R5 addi ignores rt");
    clr(); set_ex(13, 0, 14, 15); s_exm_rw = 1; s_exm_w = 15;
    apply(2'b00, 2'b00, 0, 0, 0, "R5 ori ignores rt");
    clr(); set_ex(0, 0, 12, 13); s_exm_rw = 1; s_exm_w = 12; s_mwb_rw = 1; s_mwb_w = 13;
    apply(2'b00, 2'b10, 0, 0, 0, "R5 sll reads only rt");
    clr(); set_ex(0, 1, 5, 6); s_exm_rw = 1; s_exm_w = 5; s_mwb_rw = 1; s_mwb_w = 6;
    apply(2'b00, 2'b00, 0, 0, 0, "R5 halt reads nothing");
    clr(); set_ex(43, 0, 1, 2); s_exm_rw = 1; s_exm_w = 2;
    apply(2'b00, 2'b01, 0, 0, 0, "R5 sw reads rt");
    clr(); set_ex(4, 0, 3, 3); s_mwb_rw = 1; s_mwb_w = 3;
    apply(2'b10, 2'b10, 0, 0, 0, "R5 beq reads both");

    // load-use
    clr(); set_ex(35, 0, 1, 8); s_ex_mr = 1; s_ex_wreg = 8; set_id(0, 32, 8, 1);
    apply(2'b00, 2'b00, 1, 0, 1, "R6 load then add rs");
    clr(); set_ex(35, 0, 1, 8); s_ex_mr = 1; s_ex_wreg = 8; set_id(43, 0, 1, 8);
    apply(2'b00, 2'b00, 1, 0, 1, "R6 load then sw rt");
    clr(); set_ex(35, 0, 1, 8); s_ex_mr = 1; s_ex_wreg = 8; set_id(8, 0, 1, 8);
    apply(2'b00, 2'b00, 0, 0, 0, "R5 addi rt unread no stall");
    clr(); set_ex(35, 0, 1, 8); s_ex_mr = 1; s_ex_wreg = 8; set_id(0, 0, 8, 2);
    apply(2'b00, 2'b00, 0, 0, 0, "R5 sll rs unread no stall");
    clr(); set_ex(35, 0, 1, 8); s_ex_mr = 1; s_ex_wreg = 8; set_id(0, 1, 8, 8);
    apply(2'b00, 2'b00, 0, 0, 0, "R5 halt in decode no stall");
    clr(); set_ex(35, 0, 1, 0); s_ex_mr = 1; s_ex_wreg = 0; set_id(0, 32, 0, 0);
    apply(2'b00, 2'b00, 0, 0, 0, "R4 load to zero no stall");
    clr(); set_ex(0, 32, 1, 2); s_ex_wreg = 8; set_id(0, 32, 8, 8);
    s_exm_rw = 1; s_exm_w = 8; s_mwb_rw = 1; s_mwb_w = 8;
    apply(2'b00, 2'b00, 0, 0, 0, "R7 non-load dependence no stall");
    clr(); set_ex(35, 0, 1, 8); s_ex_mr = 1; s_ex_wreg = 8; set_id(0, 32, 9, 10);
    apply(2'b00, 2'b00, 0, 0, 0, "R7 load without dependence");

    // redirects
    clr(); s_pred = 1;
    apply(2'b00, 2'b00, 0, 1, 0, "R8 predicted taken clears front");
    clr(); s_mis = 1;
    apply(2'b00, 2'b00, 0, 1, 1, "R9 mispredict clears both");
    clr(); set_ex(35, 0, 1, 8); s_ex_mr = 1; s_ex_wreg = 8; set_id(0, 32, 8, 1); s_mis = 1;
    apply(2'b00, 2'b00, 0, 1, 1, "R9 mispredict overrides stall");
    clr(); s_pred = 1; s_mis = 1;
    apply(2'b00, 2'b00, 0, 1, 1, "R9 mispredict with prediction");
    clr(); set_ex(35, 0, 1, 8); s_ex_mr = 1; s_ex_wreg = 8; set_id(4, 0, 8, 3); s_pred = 1;
    apply(2'b00, 2'b00, 1, 0, 1, "R10 stall defers prediction");

    clr();
    apply(2'b00, 2'b00, 0, 0, 0, "R4 idle after sequence");
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule